// File: doc/BRIEF.md
# Round-Robin Arbiter with Grant Hold

This block shares one resource among a configurable number of requesters. Each requester drives one bit of a request vector. The block answers with a one-hot grant vector, or with all zeros when nobody is asking. A port that wins keeps the grant for as long as it holds its request high. When it lets go, the search for the next winner starts at the index just above the last winner and wraps back to index 0. The grant therefore moves around the ports in a fair cycle.

The block remembers the index of the last granted port. That index changes only on clock edges where some grant is issued, so idle cycles do not lose the rotation point. A build-time switch selects the output timing. With one setting the grant follows the requests in the same cycle through combinational logic. With the other setting the grant is taken from a register and appears one clock later.

Top module: `rr_arbiter`

## Requirements
- R1: When no request bit is set, the grant vector is all zeros. With COMB_GRANT=1 this holds in the same cycle.
- R2: When any request bit is set, exactly one grant bit is high, and it belongs to a port whose request is set. Bit i of the grant vector belongs to port i.
- R3: If the port granted in the previous cycle still has its request set, it keeps the grant, whatever other requests arrive.
- R4: When the granted port drops its request, the grant goes to the requesting port with the lowest index above the last granted index.
- R5: If no port above the last granted index is requesting, the grant goes to the lowest-index requesting port, wrapping around.
- R6: After reset the last-grant index equals NUM_PORTS-1, so port 0 has first priority when several ports request.
- R7: Cycles with no request leave the last-grant index unchanged. After an idle gap the search starts just above the last winner, and that winner gets no hold.
- R8: With COMB_GRANT=1 the grant reflects the request vector of the same cycle.
- R9: With COMB_GRANT=0 the grant equals the grant the combinational path would have given one clock earlier. The registered grant clears to zero on the active-low synchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqIn | input | NUM_PORTS | One request bit per port |
| grantOut | output | NUM_PORTS | One-hot grant, zero when idle |

## Verification
The bench builds two copies of the block side by side, both with NUM_PORTS=4. One copy has COMB_GRANT=1 and the other has COMB_GRANT=0, and both receive the same request stream. Four ports are enough for a wrap from the top index, a skip over non-requesting ports, a hold while a lower port asks, and a resume after an idle gap. Because both copies see the same requests, each grant from the registered copy can be compared with the grant the combinational copy gave one cycle earlier.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic holdSel;   // reuse the last winner
    logic searchEn;  // run the rotating search
  } arbStrobe_t;
endpackage

// File: rtl/rr_prio_enc.sv
module rr_prio_enc #(
  parameter int WIDTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] idxOut,
  output logic             validOut
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idxOut   = '0;
    validOut = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        idxOut   = IDX_W'(i);
        validOut = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_arb_control.sv
module rr_arb_control
  import rr_arb_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic [IDX_W-1:0]     winIdx,
  input  logic                 anyWin,
  output logic [IDX_W-1:0]     lastIdx,
  output arbStrobe_t           strobe
);
  logic prevValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx   <= IDX_W'(NUM_PORTS - 1);
      prevValid <= 1'b0;
    end else begin
      prevValid <= anyWin;
      if (anyWin) lastIdx <= winIdx;
    end
  end

  always_comb begin
    strobe.holdSel  = prevValid && reqIn[lastIdx];
    strobe.searchEn = !strobe.holdSel;
  end

  // R3: a still-requesting previous winner is chosen again
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && reqIn[lastIdx]) |-> (anyWin && winIdx == lastIdx));

  // R7: idle cycles keep the rotation point
  assert_idle_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !anyWin) |=> $stable(lastIdx));
endmodule

// File: rtl/rr_arb_datapath.sv
module rr_arb_datapath
  import rr_arb_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int IDX_W      = 1,
  parameter bit COMB_GRANT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic [IDX_W-1:0]     lastIdx,
  input  arbStrobe_t           strobe,
  output logic [IDX_W-1:0]     winIdx,
  output logic                 anyWin,
  output logic [NUM_PORTS-1:0] grantOut
);
  logic [NUM_PORTS-1:0] upperReq;
  logic [NUM_PORTS-1:0] nextGrant;
  logic [IDX_W-1:0]     upperIdx, fullIdx;
  logic                 upperValid, fullValid;

  // Keep only requests above the pivot
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++)
      upperReq[i] = reqIn[i] && (IDX_W'(i) > lastIdx);
  end

  rr_prio_enc #(.WIDTH(NUM_PORTS), .IDX_W(IDX_W)) u_encUpper (
    .vecIn(upperReq), .idxOut(upperIdx), .validOut(upperValid));

  rr_prio_enc #(.WIDTH(NUM_PORTS), .IDX_W(IDX_W)) u_encFull (
    .vecIn(reqIn), .idxOut(fullIdx), .validOut(fullValid));

  always_comb begin
    if (strobe.holdSel) begin
      winIdx = lastIdx;
      anyWin = 1'b1;
    end else begin
      winIdx = (strobe.searchEn && upperValid) ? upperIdx : fullIdx;
      anyWin = fullValid;
    end
    for (int i = 0; i < NUM_PORTS; i++)
      nextGrant[i] = anyWin && (winIdx == IDX_W'(i));
  end

  generate
    if (COMB_GRANT) begin : g_comb
      assign grantOut = nextGrant;
    end else begin : g_reg
      logic [NUM_PORTS-1:0] grantQ;
      always_ff @(posedge clk) begin
        if (!rstN) grantQ <= '0;
        else       grantQ <= nextGrant;
      end
      assign grantOut = grantQ;

      // R9: registered grant lags the combinational choice by one clock
      assert_reg_lag_R9: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (grantOut == $past(nextGrant)));
    end
  endgenerate

  // R1: nothing requested, nothing granted
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn == '0) |-> (nextGrant == '0));

  // R2: one-hot grant to a requesting port
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn != '0) |-> ($countones(nextGrant) == 1 && (nextGrant & ~reqIn) == '0));

  assert_onehot0_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter
  import rr_arb_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter bit COMB_GRANT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqIn,
  output logic [NUM_PORTS-1:0] grantOut
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [IDX_W-1:0] winIdx, lastIdx;
  logic             anyWin;
  arbStrobe_t       strobe;

  rr_arb_control #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .winIdx(winIdx),
    .anyWin(anyWin), .lastIdx(lastIdx), .strobe(strobe));

  rr_arb_datapath #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W),
                    .COMB_GRANT(COMB_GRANT)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lastIdx(lastIdx),
    .strobe(strobe), .winIdx(winIdx), .anyWin(anyWin), .grantOut(grantOut));
endmodule

// File: tb/rr_arbiter_tb.sv
`timescale 1ns/1ps
module rr_arbiter_tb;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] req = '0;
  logic [NP-1:0] grantComb, grantReg;
  logic [NP-1:0] prevExp = '0;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  rr_arbiter #(.NUM_PORTS(NP), .COMB_GRANT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(req), .grantOut(grantComb));

  rr_arbiter #(.NUM_PORTS(NP), .COMB_GRANT(1'b0)) u_dutReg (
    .clk(clk), .rstN(rstN), .reqIn(req), .grantOut(grantReg));

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Drive requests, then check both outputs in the same cycle
  task automatic step(logic [NP-1:0] r, logic [NP-1:0] exp, string tag);
    @(negedge clk);
    req = r;
    #1;
    check({tag, " comb R8"}, grantComb, exp);
    check({tag, " reg R9"}, grantReg, prevExp);
    prevExp = exp;
  endtask

  task automatic doReset(logic [NP-1:0] r);
    @(negedge clk);
    rstN = 1'b0;
    req  = r;
    @(negedge clk);
    #1;
    check("R9 reg clears on reset", grantReg, '0);
    rstN = 1'b1;
    req  = '0;
    prevExp = '0;
  endtask

  task automatic testReset();
    doReset('0);
    #1;
    check("R1 idle after reset", grantComb, '0);
    step(4'b1111, 4'b0001, "R6 port0 first");
  endtask

  task automatic testHold();
    step(4'b1111, 4'b0001, "R3 hold port0");
    step(4'b1110, 4'b0010, "R4 next after 0");
    step(4'b1011, 4'b0010, "R3 hold vs lower req");
  endtask

  task automatic testRotateWrap();
    step(4'b1001, 4'b1000, "R4 skip idle port2");
    step(4'b0011, 4'b0001, "R5 wrap to 0");
    step(4'b0000, 4'b0000, "R1 idle");
  endtask

  task automatic testIdleResume();
    step(4'b0011, 4'b0010, "R7 resume after 0");
    step(4'b0100, 4'b0100, "R2 single requester");
    step(4'b0100, 4'b0100, "R3 hold single");
    step(4'b0000, 4'b0000, "R1 idle again");
    step(4'b0100, 4'b0100, "R7 same port after gap");
    step(4'b0000, 4'b0000, "R1 drain");
  endtask

  task automatic testMidReset();
    step(4'b1000, 4'b1000, "R2 port3 alone");
    doReset(4'b1111);
    step(4'b0110, 4'b0010, "R6 lowest after reset");
    step(4'b0000, 4'b0000, "R1 final idle");
    step(4'b0000, 4'b0000, "R9 final settle");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testHold();
    testRotateWrap();
    testIdleResume();
    testMidReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule